// File: doc/BRIEF.md
# One-Shot Interval Timer with Selectable Tick Rate

This block is an 8-bit one-shot interval timer that runs from a 32.768 kHz reference clock. Software programs a compare value and picks one of four tick rates, then sets a run bit. On each tick the counter either moves up by one or, if it already equals the compare value, ends the interval. At the end of the interval the block raises a sticky timeout flag and clears its own run bit. The counter then goes back to zero, and the compare and rate settings stay as they were, so setting the run bit again repeats the same interval.

A byte-wide register port has a write strobe, an address and combinational read data. A power bit acts as a clock gate for the prescaler and the counter. While it is low, all counting state and all settings are frozen, and the registers can still be written. The interrupt output is a level. It is high while the timeout flag and the interrupt-enable bit are both set.

Top module: `oneshot_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. Addresses 0 to 7 read as follows: 0 = control (run at bit 0), 1 = compare (8 bits), 2 = rate (bits [1:0]), 3 = power (bit 0), 4 = interrupt enable (bit 0), 5 = flags (timeout at bit 0), 6 = current count, 7 = always 0.
- R2: The compare, rate, power and interrupt-enable registers read back what was written to them, limited to the bits listed in R1. Unused bits read as 0.
- R3: After a write of 1 to the run bit at clock edge E, the counter goes up by one per tick. The timeout flag is set at edge E + (N+1)*D, where N is the compare value and D is the divide ratio of the selected rate.
- R4: Rate code 0 gives D = 1, which is one tick per reference cycle. Code 1 gives D = DIV_1K (default 32), code 2 gives D = DIV_1HZ (default 32768), and code 3 gives D = DIV_MIN (default 1966080).
- R5: A compare value of 0 ends the interval on the first tick.
- R6: At timeout the run bit reads 0 and the count reads 0. The compare and rate registers keep their values, and writing 1 to the run bit again gives the same interval.
- R7: Writing 0 to the run bit during counting clears the count to 0, and no timeout follows.
- R8: While the power bit is 0 the count does not advance and no timeout occurs, even with the run bit set. Once power is set, counting starts from where it stopped.
- R9: Writing 1 to flags bit 0 clears the timeout flag. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when the timeout flag and the interrupt-enable bit are both 1.
- R11: Writing 1 to the run bit while the timer is already running restarts the interval from count 0 with a fresh prescaler, so R3 timing applies from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with small divide ratios. It measures the interval for every compare value at the fastest rate and for a spread of values at the other rates, including compare 0 and 255. A design with an off-by-one in the compare, or a prescaler that is not cleared on start, would be a tick or a partial period early or late. Stopping partway, restarting while running and holding with power off are each followed by a long idle wait. A design that leaked a tick, forgot to clear the count or ignored the gate would show a stray timeout or a wrong count. Writing 0 to the flags, and running with interrupts disabled, separates a flag that clears on any write from a real write-one-to-clear flag. It also separates an `irq` tied to the flag from one gated by the enable bit.

// File: rtl/ost_pkg.sv
package ost_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_CMP   = 3'd1,
    A_RATE  = 3'd2,
    A_POWER = 3'd3,
    A_IRQEN = 3'd4,
    A_FLAGS = 3'd5,
    A_COUNT = 3'd6,
    A_SPARE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    RATE_REF  = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2,
    RATE_MIN  = 2'd3
  } rate_e;

endpackage

// File: rtl/ost_prescaler.sv
module ost_prescaler #(
  parameter int DIV_1K  = 32,
  parameter int DIV_1HZ = 32768,
  parameter int DIV_MIN = 1966080,
  localparam int PW     = $clog2(DIV_MIN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [PW-1:0] acc_q;
  logic [PW-1:0] last_val;

  always_comb begin
    case (rate)
      ost_pkg::RATE_REF:  last_val = '0;
      ost_pkg::RATE_MID:  last_val = PW'(DIV_1K - 1);
      ost_pkg::RATE_SLOW: last_val = PW'(DIV_1HZ - 1);
      default:            last_val = PW'(DIV_MIN - 1);
    endcase
  end

  // >= keeps a rate change mid-interval from overrunning the wrap point
  assign tick = en && (acc_q >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (tick)   acc_q <= '0;
    else if (en)     acc_q <= acc_q + 1'b1;
  end

endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] count,
  output logic             hit
);

  logic [WIDTH-1:0] cnt_q;

  // compare before increment: limit 0 matches on the first tick
  assign hit   = tick && (cnt_q == limit);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (hit)   cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ost_regs.sv
module ost_regs
  import ost_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              timeout,
  input  logic [CW-1:0]     count,
  output logic              ctrl_wr,
  output logic              run,
  output logic [CW-1:0]     cmp,
  output logic [1:0]        rate,
  output logic              gate,
  output logic              ie,
  output logic              status,
  output logic [DATA_W-1:0] rd_data
);

  logic wr_cmp, wr_rate, wr_power, wr_irqen, wr_flags;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign wr_cmp   = wr_en && (addr == A_CMP);
  assign wr_rate  = wr_en && (addr == A_RATE);
  assign wr_power = wr_en && (addr == A_POWER);
  assign wr_irqen = wr_en && (addr == A_IRQEN);
  assign wr_flags = wr_en && (addr == A_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= 1'b0;
    else if (ctrl_wr)  run <= wr_data[0];
    else if (timeout)  run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      rate <= 2'b00;
      gate <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (wr_cmp)   cmp  <= wr_data[CW-1:0];
      if (wr_rate)  rate <= wr_data[1:0];
      if (wr_power) gate <= wr_data[0];
      if (wr_irqen) ie   <= wr_data[0];
    end
  end

  // a new timeout wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       status <= 1'b0;
    else if (timeout)                 status <= 1'b1;
    else if (wr_flags && wr_data[0])  status <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data[0]      = run;
      A_CMP:   rd_data[CW-1:0] = cmp;
      A_RATE:  rd_data[1:0]    = rate;
      A_POWER: rd_data[0]      = gate;
      A_IRQEN: rd_data[0]      = ie;
      A_FLAGS: rd_data[0]      = status;
      A_COUNT: rd_data[CW-1:0] = count;
      default: rd_data         = '0;
    endcase
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int DIV_1K  = 32,
  parameter int DIV_1HZ = 32768,
  parameter int DIV_MIN = 1966080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int CW = DATA_W;

  logic          ctrl_wr, run_q, gate_q, ie_q, status_q;
  logic [CW-1:0] cmp_q, count_q;
  logic [1:0]    rate_q;
  logic          tick, timeout, clr, cnt_en;

  // any control write restarts or stops, so it also resets the datapath
  assign clr    = ctrl_wr || !run_q;
  assign cnt_en = run_q && gate_q && !ctrl_wr;

  ost_regs #(.CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .timeout (timeout),
    .count   (count_q),
    .ctrl_wr (ctrl_wr),
    .run     (run_q),
    .cmp     (cmp_q),
    .rate    (rate_q),
    .gate    (gate_q),
    .ie      (ie_q),
    .status  (status_q),
    .rd_data (rd_data)
  );

  ost_prescaler #(
    .DIV_1K  (DIV_1K),
    .DIV_1HZ (DIV_1HZ),
    .DIV_MIN (DIV_MIN)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (cnt_en),
    .rate  (rate_q),
    .tick  (tick)
  );

  ost_counter #(.WIDTH(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (tick),
    .limit (cmp_q),
    .count (count_q),
    .hit   (timeout)
  );

  assign irq = status_q && ie_q;

endmodule

// File: rtl/ost_checker.sv
module ost_checker
  import ost_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              run,
  input logic              gate,
  input logic              status,
  input logic [DATA_W-1:0] count,
  input logic              timeout,
  input logic              irq
);

  logic ctl_w, flag_w;
  assign ctl_w  = wr_en && (addr == A_CTRL);
  assign flag_w = wr_en && (addr == A_FLAGS);

  p_idle_count_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (count == '0));

  p_timeout_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $fell(run));

  p_after_hit_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (count == '0) && !run && status);

  p_gate_holds_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !ctl_w) |=> $stable(count) && !timeout);

  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && wr_data[0] && !timeout) |=> !status);

  p_zero_write_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && !wr_data[0] && status) |=> status);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

endmodule

bind oneshot_timer ost_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .run     (run_q),
  .gate    (gate_q),
  .status  (status_q),
  .count   (count_q),
  .timeout (timeout),
  .irq     (irq)
);

// File: tb/oneshot_timer_test.sv
`timescale 1ns/1ps
module oneshot_timer_test;

  localparam int D1 = 2;
  localparam int D2 = 3;
  localparam int D3 = 5;

  localparam logic [2:0] CTRL = 3'd0, CMP = 3'd1, RATE = 3'd2, POWER = 3'd3,
                         IRQEN = 3'd4, FLAGS = 3'd5, COUNT = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oneshot_timer #(.DIV_1K(D1), .DIV_1HZ(D2), .DIV_MIN(D3)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  function automatic int div_of(int s);
    case (s)
      0: return 1;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = FLAGS;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // cycles from the write edge until the flag reads 1 (or limit)
  task automatic measure(output int cyc);
    int v;
    cyc = 0;
    forever begin
      rd(FLAGS, v);
      if (v[0] || cyc >= 5000) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic idle(int n, string tag);
    int v;
    repeat (n) begin
      @(negedge clk);
      rd(FLAGS, v);
      if (v != 0) break;
    end
    check(v == 0 && irq == 1'b0, tag, v, 0);
  endtask

  task automatic run_one(int s, int n, string tag);
    int cyc, v, exp;
    exp = (n + 1) * div_of(s);
    wr(RATE, 8'(s));
    wr(CMP, 8'(n));
    wr(CTRL, 8'd1);
    measure(cyc);
    check(cyc == exp, tag, cyc, exp);
    rd(CTRL, v);
    check(v == 0, "R6 run self-clear", v, 0);
    rd(COUNT, v);
    check(v == 0, "R6 count back to 0", v, 0);
    rd(CMP, v);
    check(v == n, "R6 compare kept", v, n);
    rd(RATE, v);
    check(v == s, "R6 rate kept", v, s);
    wr(FLAGS, 8'd1);
    rd(FLAGS, v);
    check(v == 0, "R9 w1c", v, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, cyc;
    int nl[6] = '{0, 1, 2, 7, 100, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 0, "R1 reset reads 0", v, 0);
    end
    check(irq == 1'b0, "R1 irq low", int'(irq), 0);

    // R2 readback and field widths
    wr(CMP, 8'hA5);   rd(CMP, v);   check(v == 8'hA5, "R2 compare", v, 8'hA5);
    wr(RATE, 8'hFF);  rd(RATE, v);  check(v == 3, "R2 rate field", v, 3);
    wr(POWER, 8'hFF); rd(POWER, v); check(v == 1, "R2 power field", v, 1);
    wr(IRQEN, 8'hFE); rd(IRQEN, v); check(v == 0, "R2 irqen field", v, 0);
    wr(IRQEN, 8'h01); rd(IRQEN, v); check(v == 1, "R2 irqen set", v, 1);
    rd(3'd7, v); check(v == 0, "R1 spare address", v, 0);

    // R3 R4 R5: every compare value at the reference rate
    for (int n = 0; n < 256; n++) run_one(0, n, "R3 R5 interval rate0");
    // R4: other rates, boundary values
    for (int s = 1; s < 4; s++)
      foreach (nl[i]) run_one(s, nl[i], "R4 interval by rate");

    // R6: repeat with only a run write
    wr(RATE, 8'd3); wr(CMP, 8'd4);
    for (int k = 0; k < 2; k++) begin
      wr(CTRL, 8'd1);
      measure(cyc);
      check(cyc == 5 * D3, "R6 repeat interval", cyc, 5 * D3);
      check(irq == 1'b1, "R10 irq with enable", int'(irq), 1);
      wr(FLAGS, 8'd1);
    end

    // R7: stop partway
    wr(RATE, 8'd1); wr(CMP, 8'd10); wr(CTRL, 8'd1);
    repeat (6) @(negedge clk);
    rd(COUNT, v);
    check(v == 7 / D1, "R3 count mid interval", v, 7 / D1);
    wr(CTRL, 8'd0);
    rd(COUNT, v);
    check(v == 0, "R7 stop clears count", v, 0);
    idle(200, "R7 no timeout after stop");

    // R11: restart while running
    wr(RATE, 8'd2); wr(CMP, 8'd4); wr(CTRL, 8'd1);
    repeat (8) @(negedge clk);
    wr(CTRL, 8'd1);
    measure(cyc);
    check(cyc == 5 * D2, "R11 restart interval", cyc, 5 * D2);

    // R9: writing 0 keeps the flag; R10 follows enable
    wr(FLAGS, 8'd0);
    rd(FLAGS, v);
    check(v == 1, "R9 zero write ignored", v, 1);
    wr(IRQEN, 8'd0);
    check(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    wr(IRQEN, 8'd1);
    check(irq == 1'b1, "R10 irq unmasked", int'(irq), 1);
    wr(FLAGS, 8'd1);
    check(irq == 1'b0, "R10 irq drops with flag", int'(irq), 0);

    // R8: gated clock holds everything
    wr(POWER, 8'd0); wr(RATE, 8'd0); wr(CMP, 8'd3); wr(CTRL, 8'd1);
    idle(100, "R8 no timeout while gated");
    rd(COUNT, v);  check(v == 0, "R8 count frozen", v, 0);
    rd(CTRL, v);   check(v == 1, "R8 run retained", v, 1);
    rd(CMP, v);    check(v == 3, "R8 compare retained", v, 3);
    wr(POWER, 8'd1);
    measure(cyc);
    check(cyc == 4, "R8 resumes after ungate", cyc, 4);
    wr(FLAGS, 8'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule